// File: doc/BRIEF.md
# NAND Ready-Edge Interrupt Unit

This unit watches the ready/busy line of a NAND flash device and raises an interrupt when the line returns from busy to ready. Software can therefore start a long program or erase operation and sleep, instead of polling the device. Only the completion edge counts. A ready line that stays high, or a falling edge, leaves the status alone.

The unit holds four sticky pending bits. Bit 0 records the ready edge. Bits 3:1 record one-cycle event pulses from neighbouring logic. Software clears a pending bit by writing a one to it. A byte-wide mask register selects which pending bits may reach the single interrupt line. Its top bit is a global enable that gates all of them. In normal use the mask is zero. Software sets the global enable together with the ready enable just before it waits, and writes zero to the mask again when it wakes.

Top module: `rdy_edge_irq`

## Requirements
- R1: The ready/busy input passes through a two-flop synchronizer and one more history flop. A low-to-high transition on the input sampled at clock edge k sets pending bit 0 at edge k+2. A falling edge, or a line that stays high, sets nothing.
- R2: A one-cycle high on event input bit j (j = 1..3) at a clock edge sets pending bit j at that edge.
- R3: A pending bit stays set until software clears it, whatever the inputs do in the meantime.
- R4: A write with addr_i = 0 clears each pending bit whose matching bit in wr_data_i[3:0] is one. Bits written as zero are left unchanged, and wr_data_i[7:4] has no effect.
- R5: If a set event and a clearing write hit the same bit at the same edge, the set wins and the bit stays pending.
- R6: A write with addr_i = 1 loads all 8 bits of the mask register. A read with addr_i = 1 returns the mask.
- R7: irq_o is registered. After each edge it equals mask[7] AND (OR over i of pending[i] AND mask[i], i = 0..3), using the state that held before that edge.
- R8: Reset (synchronous, active high) clears the pending bits, the mask, irq_o and rd_data_o.
- R9: rd_data_o is registered. After each edge it shows the register selected by addr_i at that edge. A status read (addr_i = 0) returns the pending bits in 3:0 and zeros in 7:4.
- R10: Writing a mask with bit 7 clear drops irq_o one edge after the write, even while bits remain pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_busy_i | input | 1 | NAND ready/busy line, high = ready, asynchronous |
| evt_i | input | 3 | One-cycle event pulses for pending bits 3:1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = status, 1 = mask |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives inputs at falling edges and samples outputs at falling edges. It keeps a reference state that advances at each rising edge, using the latencies stated in the requirements. An event pulse or a clearing write shows up on rd_data_o one edge later and on irq_o at that same edge. A ready rise appears three edges after its first sampling edge, because of the two synchronizer flops and the history flop. On top of the continuous comparison, directed checks count falling edges explicitly. irq_o must still be low at the third falling edge after the ready rise and high at the fourth. After a mask write that disables the interrupt, irq_o must be low at the second falling edge.

// File: rtl/rdy_edge_irq_pkg.sv
package rdy_edge_irq_pkg;
  localparam int unsigned STAT_W     = 4;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned MASTER_BIT = 7;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_MASK   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rdy_edge_sync.sv
module rdy_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q[s] <= 1'b0;
        end else begin
          if (s == 0) sync_q[s] <= async_i;
          else        sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~hist_q;
endmodule

// File: rtl/rdy_sticky_bits.sv
module rdy_sticky_bits #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)           pend_o[b] <= 1'b0;
        else if (set_i[b]) pend_o[b] <= 1'b1;
        else if (clr_i[b]) pend_o[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/rdy_irq_gate.sv
module rdy_irq_gate #(
  parameter int unsigned STAT_W     = 4,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned MASTER_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] pend_i,
  input  logic [REG_W-1:0]  mask_i,
  output logic              irq_o
);
  logic any_hit;
  assign any_hit = |(pend_i & mask_i[STAT_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= mask_i[MASTER_BIT] & any_hit;
  end
endmodule

// File: rtl/rdy_edge_irq.sv
module rdy_edge_irq
  import rdy_edge_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_busy_i,
  input  logic [STAT_W-1:1] evt_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = REG_W - STAT_W;

  logic              rdy_rise;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] pend_q;
  logic [REG_W-1:0]  mask_q;
  logic              stat_wr;
  logic              mask_wr;

  assign stat_wr = wr_en_i && (reg_sel_e'(addr_i) == SEL_STATUS);
  assign mask_wr = wr_en_i && (reg_sel_e'(addr_i) == SEL_MASK);

  rdy_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (rdy_busy_i),
    .rise_o  (rdy_rise)
  );

  assign set_vec = {evt_i, rdy_rise};
  assign clr_vec = stat_wr ? wr_data_i[STAT_W-1:0] : '0;

  rdy_sticky_bits #(.WIDTH(STAT_W)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data_i;
  end

  rdy_irq_gate #(.STAT_W(STAT_W), .REG_W(REG_W), .MASTER_BIT(MASTER_BIT)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                               rd_data_o <= '0;
    else if (reg_sel_e'(addr_i) == SEL_MASK) rd_data_o <= mask_q;
    else                                   rd_data_o <= {{PAD_W{1'b0}}, pend_q};
  end
endmodule

// File: rtl/rdy_edge_irq_chk.sv
module rdy_edge_irq_chk
  import rdy_edge_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rdy_rise,
  input logic [STAT_W-1:0] set_vec,
  input logic [STAT_W-1:0] clr_vec,
  input logic [STAT_W-1:0] pend_q,
  input logic [REG_W-1:0]  mask_q,
  input logic              mask_wr,
  input logic [REG_W-1:0]  wr_data_i,
  input logic              addr_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              irq_o
);
  AST_RISE_SETS_BIT0: assert property (@(posedge clk) disable iff (rst)
    rdy_rise |=> pend_q[0]); // R1

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (set_vec[1] && clr_vec[1]) |=> pend_q[1]); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (pend_q[2] && !clr_vec[2]) |=> pend_q[2]); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr_vec[3] && !set_vec[3]) |=> !pend_q[3]); // R4

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(mask_q[MASTER_BIT])); // R7

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask_q == $past(wr_data_i))); // R6

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(addr_i) |-> (rd_data_o[REG_W-1:STAT_W] == '0)); // R9

  AST_DISABLE_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    $past(mask_wr && !wr_data_i[MASTER_BIT], 2) |-> !irq_o); // R10
endmodule

bind rdy_edge_irq rdy_edge_irq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdy_rise  (rdy_rise),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .pend_q    (pend_q),
  .mask_q    (mask_q),
  .mask_wr   (mask_wr),
  .wr_data_i (wr_data_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/rdy_edge_irq_tb_top.sv
module rdy_edge_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rdy = 1'b0;
  logic [3:1] evt = '0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit run_chk = 1'b0;
  string cur_req = "R3";

  always #10 clk = ~clk;

  rdy_edge_irq dut_i (
    .clk        (clk),
    .rst        (rst),
    .rdy_busy_i (rdy),
    .evt_i      (evt),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wr_data_i  (wdata),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  // Reference state built from the requirements
  logic [1:0] m_sync;
  logic       m_hist;
  logic [3:0] m_pend;
  logic [7:0] m_mask;
  logic [7:0] m_rd;
  logic       m_irq;

  function automatic logic f_irq(input logic [7:0] msk, input logic [3:0] pnd);
    return msk[7] & |(pnd & msk[3:0]);
  endfunction

  function automatic logic [3:0] f_next_pend(input logic [3:0] pnd, input logic [3:0] set,
                                             input logic [3:0] clr);
    return set | (pnd & ~clr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sync <= '0; m_hist <= 1'b0; m_pend <= '0; m_mask <= '0; m_rd <= '0; m_irq <= 1'b0;
    end else begin
      m_sync <= {m_sync[0], rdy};
      m_hist <= m_sync[1];
      m_pend <= f_next_pend(m_pend, {evt, m_sync[1] & ~m_hist},
                            (wr_en && !addr) ? wdata[3:0] : 4'h0);
      if (wr_en && addr) m_mask <= wdata;
      m_rd  <= addr ? m_mask : {4'h0, m_pend};
      m_irq <= f_irq(m_mask, m_pend);
    end
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run_chk && !rst) begin
      check("R7", {7'd0, irq}, {7'd0, m_irq});
      check(cur_req, rd_data, m_rd);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; evt = '0;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R8: outputs cleared by reset
    check("R8", rd_data, 8'h00);
    check("R8", {7'd0, irq}, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R8", rd_data, 8'h00);
    run_chk = 1'b1;

    // R6: mask written and read back
    cur_req = "R6";
    wr(1'b1, 8'h81);
    addr = 1'b1;
    @(negedge clk);
    check("R6", rd_data, 8'h81);
    addr = 1'b0;

    // R1 + R7: ready rise reaches irq at the fourth falling edge
    cur_req = "R1";
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R1", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R1", {7'd0, irq}, 8'h01);
    check("R9", rd_data, 8'h01);
    idle(5);

    // R10: disabling mask drops irq with bit still pending
    cur_req = "R10";
    @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'h00;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0;
    @(negedge clk);
    check("R10", {7'd0, irq}, 8'h00);
    check("R10", rd_data, 8'h01);

    // R1: falling edge and held level set nothing after clear
    cur_req = "R4";
    wr(1'b0, 8'hFF);
    idle(2);
    check("R4", rd_data, 8'h00);
    cur_req = "R1";
    rdy = 1'b0; idle(6);
    check("R1", rd_data, 8'h00);

    // R2 + R9: event pulses, upper read bits zero
    cur_req = "R2";
    @(negedge clk); evt = 3'b101;
    @(negedge clk); evt = '0;
    @(negedge clk);
    check("R2", rd_data, 8'h0A);

    // R5: set and clear collide on bit 1
    cur_req = "R5";
    @(negedge clk); evt = 3'b001; wr_en = 1'b1; addr = 1'b0; wdata = 8'h0F;
    @(negedge clk); evt = '0; wr_en = 1'b0;
    @(negedge clk);
    check("R5", rd_data, 8'h02);

    // R7: master enable off with bit enables on gives no irq
    cur_req = "R7";
    wr(1'b1, 8'h0F);
    idle(2);
    check("R7", {7'd0, irq}, 8'h00);
    wr(1'b1, 8'h82);
    idle(2);
    check("R7", {7'd0, irq}, 8'h01);

    // R3: random mix against reference state
    cur_req = "R3";
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 7) == 0) rdy = ~rdy;
      evt   = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      wr_en = ($urandom_range(0, 4) == 0);
      addr  = 1'($urandom);
      wdata = 8'($urandom);
      if (wr_en && addr && $urandom_range(0, 1) == 1) wdata[7] = 1'b1;
    end
    idle(6);
    run_chk = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule